// File: doc/BRIEF.md
# Receive Descriptor Writeback Engine

This block is the memory-side half of a receive DMA channel. Descriptors sit in a circular ring in memory, 32 bytes apart. Each one holds a buffer address word, a control word and an auxiliary word. When a frame begins, the engine reads the control word of the current descriptor. If hardware owns that descriptor, the engine then reads the buffer address. It packs the incoming bytes into 32-bit little-endian writes and stops storing once the buffer is full.

When the frame ends, the engine writes the auxiliary word first. This word carries the source port and the CRC error flag. Next it writes the control word, which carries the stored length, the classification flags, the segment markers and the preserved end-of-ring marker. Last, it hands the descriptor to software with a separate write of the top byte only. A one-cycle interrupt pulse follows that write, and the ring pointer then moves to the next descriptor.

Frame parsing, checksum checking and CRC checking happen upstream. Their results arrive as sideband signals with the last byte of the frame. The suspend input holds the engine idle between frames.

Top module: `rx_desc_writeback`

## Requirements
- R1: After synchronous reset, `rx_ready_o`, `mem_req_o`, `irq_o` and `drop_count_o` are 0, and `desc_ptr_o` equals `ring_base_i`.
- R2: A first byte (`rx_valid_i` and `rx_sof_i`) that arrives while not suspended causes a read of descriptor offset 4, the control word. If bit 31 of that word is 0, hardware owns the descriptor and a read of offset 0, the buffer address, follows. Memory read data returns one cycle after the request.
- R3: A stored frame byte with index k goes to byte address buffer+k. Writes are whole aligned words with lane k mod 4 at bits 8*(k mod 4)+7:8*(k mod 4), and the byte enables mark only the written bytes. Bytes outside the stored length are left untouched, and no memory read is made while `rx_ready_o` is high.
- R4: The byte limit is the lower of control bits 15:0 and MAX_FRAME (default 9500). Bytes beyond the limit are not written. The length field then reports the limit, and the CRC error flag is set.
- R5: The written-back control word has bits 15:0 = stored length, bit 16 = L4 checksum failure, bit 17 = IP checksum failure, bits 21:18 = protocol code, bit 28 = 1 (last segment), bit 29 = 1 (first segment), bit 30 = the end-of-ring bit as fetched, bits 27:22 = 0 and bit 31 = 1 once the frame is complete.
- R6: The written-back auxiliary word (offset 8) has bits 10:8 = source port, bit 11 = CRC error (sideband flag or truncation), and all other bits 0.
- R7: The ownership bit is set by a write to offset 4 with byte enable 4'b1000. This write comes after the full-word writes of offset 8 and offset 4, and only one such write is made per frame.
- R8: Exactly one `irq_o` pulse is raised per written-back descriptor, in the cycle after the ownership write.
- R9: After a writeback the pointer advances by 32 bytes. After a descriptor whose bit 30 is set, it returns to `ring_base_i`.
- R10: If bit 31 of the fetched control word is 1 (software owned), the whole frame is consumed with no memory write. In that case `drop_count_o` rises by one, the pointer is unchanged and no interrupt is raised.
- R11: While `suspend_i` is high, a waiting first byte is not accepted, `rx_ready_o` stays 0 and no memory access is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| suspend_i | input | 1 | Hold off new frames |
| ring_base_i | input | ADDR_W | Byte address of the first descriptor |
| desc_ptr_o | output | ADDR_W | Byte address of the current descriptor |
| rx_valid_i | input | 1 | Frame byte valid |
| rx_ready_o | output | 1 | Engine accepts a byte this cycle |
| rx_sof_i | input | 1 | Byte is the first of a frame |
| rx_eof_i | input | 1 | Byte is the last of a frame |
| rx_data_i | input | 8 | Frame byte |
| rx_port_i | input | 3 | Source port, valid with the last byte |
| rx_proto_i | input | 4 | Protocol code, valid with the last byte |
| rx_l4_fail_i | input | 1 | L4 checksum failure, valid with the last byte |
| rx_ip_fail_i | input | 1 | IP checksum failure, valid with the last byte |
| rx_crc_err_i | input | 1 | CRC error, valid with the last byte |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | ADDR_W | Byte address (word aligned) |
| mem_be_o | output | 4 | Byte enables for writes |
| mem_wdata_o | output | 32 | Write data |
| mem_rdata_i | input | 32 | Read data, one cycle after a read request |
| irq_o | output | 1 | Receive-complete pulse |
| drop_count_o | output | DROP_W | Frames dropped on software-owned descriptors |

## Verification
Random frames are run with random lengths against random buffer sizes. This covers frames that end in every byte lane and frames that are both shorter and longer than the buffer. The stored bytes, the untouched bytes beyond the limit, the length field and the CRC flag therefore separate correct truncation from off-by-one errors. Directed frames cover a length equal to the buffer size, one byte over it, a single-byte buffer, and a buffer larger than the frame cap. Further directed cases cover a software-owned descriptor and a start held off by suspend. Running past the last descriptor shows the wrap to the ring base. A write-order monitor on the memory port shows that the ownership bit always arrives last.

// File: rtl/rxwb_pkg.sv
package rxwb_pkg;

    localparam int SIZE_W     = 16;
    localparam int DESC_BYTES = 32;
    localparam int OFS_BUF    = 0;
    localparam int OFS_CTL    = 4;
    localparam int OFS_AUX    = 8;
    localparam int OWN_BIT    = 31;
    localparam int EOR_BIT    = 30;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH_CTL,
        ST_FETCH_PTR,
        ST_STREAM,
        ST_DISCARD,
        ST_WB_AUX,
        ST_WB_CTL,
        ST_WB_OWN
    } rxwb_state_e;

    typedef struct packed {
        logic [2:0] port;
        logic [3:0] proto;
        logic       l4_fail;
        logic       ip_fail;
        logic       crc_err;
    } rx_status_t;

    // control word: own | eor | first | last | 6'b0 | proto | ip | l4 | length
    function automatic logic [31:0] ctl_word(input logic [SIZE_W-1:0] len,
                                             input rx_status_t st,
                                             input logic eor,
                                             input logic own);
        return {own, eor, 1'b1, 1'b1, 6'b0, st.proto, st.ip_fail, st.l4_fail, len};
    endfunction

    // auxiliary word: crc error at bit 11, port at bits 10:8
    function automatic logic [31:0] aux_word(input rx_status_t st, input logic crc);
        return {20'b0, crc, st.port, 8'b0};
    endfunction

endpackage

// File: rtl/rxwb_ring_ptr.sv
module rxwb_ring_ptr #(
    parameter int ADDR_W = 32,
    parameter int STEP   = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] base_i,
    input  logic              advance_i,
    input  logic              wrap_i,
    output logic [ADDR_W-1:0] ptr_o
);
    localparam logic [ADDR_W-1:0] STEP_A = ADDR_W'(STEP);

    logic [ADDR_W-1:0] ptr_q;

    always_ff @(posedge clk) begin
        if (rst)            ptr_q <= base_i;
        else if (advance_i) ptr_q <= wrap_i ? base_i : ptr_q + STEP_A;
    end

    assign ptr_o = ptr_q;

    // R9: a step either wraps to the base or moves one descriptor on
    p_ptr_step_r9: assert property (@(posedge clk) disable iff (rst)
        advance_i |=> (ptr_q == $past(base_i) || ptr_q == $past(ptr_q) + STEP_A));

endmodule

// File: rtl/rxwb_packer.sv
module rxwb_packer #(
    parameter int ADDR_W  = 32,
    parameter int LEN_W   = 16,
    parameter int MAX_LEN = 9500
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [LEN_W-1:0]  limit_i,
    input  logic [ADDR_W-1:0] buf_i,
    input  logic              byte_vld_i,
    input  logic [7:0]        byte_i,
    input  logic              eof_i,
    output logic              wr_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [31:0]       wr_data_o,
    output logic [3:0]        wr_be_o,
    output logic [LEN_W-1:0]  len_o,
    output logic              trunc_o
);
    localparam logic [LEN_W-1:0] CAP = LEN_W'(MAX_LEN);

    logic [LEN_W-1:0] cnt_q, lim_q;
    logic [31:0]      held_q, merged;
    logic [3:0]       hbe_q, lane_be;
    logic             trunc_q, store;
    logic [1:0]       lane;

    always_comb begin
        store   = byte_vld_i && (cnt_q < lim_q);
        lane    = cnt_q[1:0];
        lane_be = 4'b0001 << lane;
        merged  = held_q;
        merged[8*lane +: 8] = byte_i;
    end

    assign wr_o      = byte_vld_i && ((store && (lane == 2'd3 || eof_i)) ||
                                      (!store && eof_i && (|hbe_q)));
    assign wr_be_o   = hbe_q | (store ? lane_be : 4'b0000);
    assign wr_data_o = store ? merged : held_q;
    assign wr_addr_o = buf_i + ADDR_W'({cnt_q[LEN_W-1:2], 2'b00});
    assign len_o     = cnt_q;
    assign trunc_o   = trunc_q;

    always_ff @(posedge clk) begin
        if (rst || start_i) begin
            cnt_q   <= '0;
            held_q  <= '0;
            hbe_q   <= '0;
            trunc_q <= 1'b0;
            lim_q   <= rst ? '0 : ((limit_i > CAP) ? CAP : limit_i);
        end else if (byte_vld_i) begin
            if (store) cnt_q <= cnt_q + 1'b1;
            else       trunc_q <= 1'b1;
            if (wr_o) begin
                held_q <= '0;
                hbe_q  <= '0;
            end else if (store) begin
                held_q <= merged;
                hbe_q  <= hbe_q | lane_be;
            end
        end
    end

    // R4: the stored count never passes the limit
    p_len_bound_r4: assert property (@(posedge clk) disable iff (rst) cnt_q <= lim_q);
    // R3: a full word is always written out, never held
    p_no_full_hold_r3: assert property (@(posedge clk) disable iff (rst) !(&hbe_q));

endmodule

// File: rtl/rx_desc_writeback.sv
module rx_desc_writeback
    import rxwb_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int MAX_FRAME = 9500,
    parameter int DROP_W    = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              suspend_i,
    input  logic [ADDR_W-1:0] ring_base_i,
    output logic [ADDR_W-1:0] desc_ptr_o,
    input  logic              rx_valid_i,
    output logic              rx_ready_o,
    input  logic              rx_sof_i,
    input  logic              rx_eof_i,
    input  logic [7:0]        rx_data_i,
    input  logic [2:0]        rx_port_i,
    input  logic [3:0]        rx_proto_i,
    input  logic              rx_l4_fail_i,
    input  logic              rx_ip_fail_i,
    input  logic              rx_crc_err_i,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [3:0]        mem_be_o,
    output logic [31:0]       mem_wdata_o,
    input  logic [31:0]       mem_rdata_i,
    output logic              irq_o,
    output logic [DROP_W-1:0] drop_count_o
);
    localparam logic [ADDR_W-1:0] A_BUF = ADDR_W'(OFS_BUF);
    localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(OFS_CTL);
    localparam logic [ADDR_W-1:0] A_AUX = ADDR_W'(OFS_AUX);

    rxwb_state_e       state_q;
    rx_status_t        st_q, st_in;
    logic              eor_q, irq_q, start_frame, accept, sw_owned;
    logic [ADDR_W-1:0] buf_q, ptr;
    logic [DROP_W-1:0] drop_q;

    logic              pk_wr, pk_trunc;
    logic [ADDR_W-1:0] pk_addr;
    logic [31:0]       pk_data;
    logic [3:0]        pk_be;
    logic [SIZE_W-1:0] pk_len;

    assign st_in       = '{port: rx_port_i, proto: rx_proto_i, l4_fail: rx_l4_fail_i,
                           ip_fail: rx_ip_fail_i, crc_err: rx_crc_err_i};
    assign rx_ready_o  = (state_q == ST_STREAM) || (state_q == ST_DISCARD);
    assign accept      = rx_valid_i && rx_ready_o;
    assign start_frame = (state_q == ST_IDLE) && rx_valid_i && rx_sof_i && !suspend_i;
    assign sw_owned    = mem_rdata_i[OWN_BIT];

    rxwb_ring_ptr #(.ADDR_W(ADDR_W), .STEP(DESC_BYTES)) u_ptr (
        .clk       (clk),
        .rst       (rst),
        .base_i    (ring_base_i),
        .advance_i (state_q == ST_WB_OWN),
        .wrap_i    (eor_q),
        .ptr_o     (ptr)
    );

    rxwb_packer #(.ADDR_W(ADDR_W), .LEN_W(SIZE_W), .MAX_LEN(MAX_FRAME)) u_pack (
        .clk        (clk),
        .rst        (rst),
        .start_i    (state_q == ST_FETCH_CTL),
        .limit_i    (mem_rdata_i[SIZE_W-1:0]),
        .buf_i      (buf_q),
        .byte_vld_i (accept && state_q == ST_STREAM),
        .byte_i     (rx_data_i),
        .eof_i      (rx_eof_i),
        .wr_o       (pk_wr),
        .wr_addr_o  (pk_addr),
        .wr_data_o  (pk_data),
        .wr_be_o    (pk_be),
        .len_o      (pk_len),
        .trunc_o    (pk_trunc)
    );

    always_comb begin
        mem_req_o   = 1'b0;
        mem_we_o    = 1'b0;
        mem_addr_o  = ptr;
        mem_be_o    = 4'b1111;
        mem_wdata_o = '0;
        unique case (state_q)
            ST_IDLE: begin
                mem_req_o  = start_frame;
                mem_addr_o = ptr + A_CTL;
            end
            ST_FETCH_CTL: begin
                mem_req_o  = !sw_owned;
                mem_addr_o = ptr + A_BUF;
            end
            ST_STREAM: begin
                mem_req_o   = pk_wr;
                mem_we_o    = 1'b1;
                mem_addr_o  = pk_addr;
                mem_be_o    = pk_be;
                mem_wdata_o = pk_data;
            end
            ST_WB_AUX: begin
                mem_req_o   = 1'b1;
                mem_we_o    = 1'b1;
                mem_addr_o  = ptr + A_AUX;
                mem_wdata_o = aux_word(st_q, st_q.crc_err | pk_trunc);
            end
            ST_WB_CTL: begin
                mem_req_o   = 1'b1;
                mem_we_o    = 1'b1;
                mem_addr_o  = ptr + A_CTL;
                mem_wdata_o = ctl_word(pk_len, st_q, eor_q, 1'b0);
            end
            ST_WB_OWN: begin
                mem_req_o   = 1'b1;
                mem_we_o    = 1'b1;
                mem_addr_o  = ptr + A_CTL;
                mem_be_o    = 4'b1000;
                mem_wdata_o = ctl_word(pk_len, st_q, eor_q, 1'b1);
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            st_q    <= '0;
            eor_q   <= 1'b0;
            buf_q   <= '0;
            drop_q  <= '0;
            irq_q   <= 1'b0;
        end else begin
            irq_q <= (state_q == ST_WB_OWN);
            unique case (state_q)
                ST_IDLE:      if (start_frame) state_q <= ST_FETCH_CTL;
                ST_FETCH_CTL: begin
                    eor_q <= mem_rdata_i[EOR_BIT];
                    if (sw_owned) begin
                        drop_q  <= drop_q + 1'b1;
                        state_q <= ST_DISCARD;
                    end else begin
                        state_q <= ST_FETCH_PTR;
                    end
                end
                ST_FETCH_PTR: begin
                    buf_q   <= mem_rdata_i[ADDR_W-1:0];
                    state_q <= ST_STREAM;
                end
                ST_STREAM: if (accept && rx_eof_i) begin
                    st_q    <= st_in;
                    state_q <= ST_WB_AUX;
                end
                ST_DISCARD: if (accept && rx_eof_i) state_q <= ST_IDLE;
                ST_WB_AUX:  state_q <= ST_WB_CTL;
                ST_WB_CTL:  state_q <= ST_WB_OWN;
                ST_WB_OWN:  state_q <= ST_IDLE;
                default:    state_q <= ST_IDLE;
            endcase
        end
    end

    assign desc_ptr_o   = ptr;
    assign irq_o        = irq_q;
    assign drop_count_o = drop_q;

    // R8: interrupt only right after a top-byte ownership write
    p_irq_after_own_r8: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> $past(mem_req_o && mem_we_o && mem_be_o == 4'b1000));
    // R7: ownership write follows a full write of the same word with owner clear
    p_own_last_r7: assert property (@(posedge clk) disable iff (rst)
        (mem_req_o && mem_we_o && mem_be_o == 4'b1000) |->
        $past(mem_req_o && mem_we_o && mem_be_o == 4'b1111 && !mem_wdata_o[OWN_BIT])
        && mem_addr_o == $past(mem_addr_o));
    // R11: nothing reaches memory while held in idle by suspend
    p_no_fetch_suspended_r11: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && suspend_i) |-> !mem_req_o);
    // R10: a dropped frame touches no memory
    p_discard_silent_r10: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_DISCARD) |-> !mem_req_o);
    // R10: the drop count moves by one at a time
    p_drop_step_r10: assert property (@(posedge clk) disable iff (rst)
        (drop_q != $past(drop_q)) |-> (drop_q == $past(drop_q) + 1'b1));
    // R3: no reads while bytes are being taken
    p_ready_noread_r3: assert property (@(posedge clk) disable iff (rst)
        rx_ready_o |-> !(mem_req_o && !mem_we_o));

endmodule

// File: tb/rx_desc_writeback_tb_top.sv
`timescale 1ns/1ps
module rx_desc_writeback_tb_top;
    localparam int AW     = 32;
    localparam int TB_MAX = 40;
    localparam int NDESC  = 4;
    localparam logic [31:0] BASE = 32'h40;
    localparam logic [31:0] BUF0 = 32'h100;

    logic clk = 1'b0, rst = 1'b1, suspend = 1'b0;
    logic rx_valid = 0, rx_sof = 0, rx_eof = 0, l4 = 0, ipf = 0, crc = 0;
    logic [7:0] rx_data = 0;
    logic [2:0] port = 0;
    logic [3:0] proto = 0;
    logic rx_ready, mem_req, mem_we, irq;
    logic [AW-1:0] mem_addr, desc_ptr;
    logic [3:0] mem_be;
    logic [31:0] mem_wdata, mem_rdata = 0;
    logic [15:0] drops;

    always #2 clk = ~clk;

    rx_desc_writeback #(.ADDR_W(AW), .MAX_FRAME(TB_MAX), .DROP_W(16)) dut_i (
        .clk(clk), .rst(rst), .suspend_i(suspend), .ring_base_i(BASE), .desc_ptr_o(desc_ptr),
        .rx_valid_i(rx_valid), .rx_ready_o(rx_ready), .rx_sof_i(rx_sof), .rx_eof_i(rx_eof),
        .rx_data_i(rx_data), .rx_port_i(port), .rx_proto_i(proto), .rx_l4_fail_i(l4),
        .rx_ip_fail_i(ipf), .rx_crc_err_i(crc), .mem_req_o(mem_req), .mem_we_o(mem_we),
        .mem_addr_o(mem_addr), .mem_be_o(mem_be), .mem_wdata_o(mem_wdata),
        .mem_rdata_i(mem_rdata), .irq_o(irq), .drop_count_o(drops));

    logic [31:0] mem [0:127];
    int n_tests = 0, n_fail = 0;
    int writes = 0, reqs = 0, irqs = 0, own_wr = 0, own_bad = 0, rd_n = 0;
    bit seen_aux = 0, seen_ctl = 0, done = 0;
    logic [31:0] cur_desc = BASE, rd0 = 0, rd1 = 0;
    logic [7:0] fb [0:63];

    always @(posedge clk) begin
        if (irq) irqs++;
        if (mem_req) begin
            reqs++;
            if (mem_we) begin
                writes++;
                for (int b = 0; b < 4; b++)
                    if (mem_be[b]) mem[mem_addr[8:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
                if (mem_addr == cur_desc + 8 && mem_be == 4'hF) seen_aux = 1;
                if (mem_addr == cur_desc + 4 && mem_be == 4'hF) seen_ctl = 1;
                if (mem_addr == cur_desc + 4 && mem_be == 4'h8 && mem_wdata[31]) begin
                    own_wr++;
                    if (!(seen_aux && seen_ctl)) own_bad++;
                end
            end else begin
                mem_rdata <= mem[mem_addr[8:2]];
                if (rd_n == 0) rd0 = mem_addr;
                if (rd_n == 1) rd1 = mem_addr;
                rd_n++;
            end
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic arm(input int d, input int size, input bit sw_own);
        logic [31:0] da = BASE + 32 * d;
        mem[da[8:2]]     = BUF0 + 64 * d;
        mem[da[8:2] + 1] = {sw_own, (d == NDESC - 1), 2'b11, 12'b0, 16'(size)};
        mem[da[8:2] + 2] = 32'h0;
        for (int w = 0; w < 16; w++) mem[(BUF0[8:2] + 16 * d + w)] = 32'hA5A5A5A5;
    endtask

    task automatic send(input int len);
        for (int i = 0; i < len; i++) begin
            rx_valid = 1; rx_sof = (i == 0); rx_eof = (i == len - 1); rx_data = fb[i];
            while (!rx_ready) @(negedge clk);
            @(posedge clk); @(negedge clk);
        end
        rx_valid = 0; rx_sof = 0; rx_eof = 0;
    endtask

    function automatic int imin(input int a, input int b);
        return (a < b) ? a : b;
    endfunction

    int idx = 0;

    task automatic run_frame(input int size, input int len);
        int lim, len_e, bad, d, i0;
        bit trunc, crc_e;
        logic [31:0] da, w1e, w2e, bufa;
        d = idx; da = BASE + 32 * d; cur_desc = da;
        arm(d, size, 0);
        for (int k = 0; k < 64; k++) fb[k] = 8'($urandom);
        port = 3'($urandom); proto = 4'($urandom); l4 = 1'($urandom); ipf = 1'($urandom);
        crc = ($urandom % 4) == 0;
        seen_aux = 0; seen_ctl = 0; own_wr = 0; own_bad = 0; rd_n = 0; i0 = irqs;
        send(len);
        repeat (8) @(negedge clk);
        lim = imin(size, TB_MAX); len_e = imin(lim, len); trunc = len > lim; crc_e = crc | trunc;
        w1e = {1'b1, (d == NDESC - 1), 2'b11, 6'b0, proto, ipf, l4, 16'(len_e)};
        w2e = {20'b0, crc_e, port, 8'b0};
        check(rd_n == 2 && rd0 == da + 4 && rd1 == da, "R2 fetch order", rd0, da + 4);
        check(mem[da[8:2] + 1] == w1e, trunc ? "R4/R5 control word" : "R5 control word",
              mem[da[8:2] + 1], w1e);
        check(mem[da[8:2] + 2] == w2e, "R6 aux word", mem[da[8:2] + 2], w2e);
        bad = 0;
        for (int k = 0; k < 64; k++) begin
            bufa = BUF0 + 64 * d + k;
            if (mem[bufa[8:2]][8 * (k % 4) +: 8] != ((k < len_e) ? fb[k] : 8'hA5)) bad++;
        end
        check(bad == 0, trunc ? "R4 truncated buffer" : "R3 buffer bytes", bad, 0);
        check(own_wr == 1 && own_bad == 0, "R7 ownership last", own_wr, 1);
        check(irqs - i0 == 1, "R8 one irq", irqs - i0, 1);
        idx = (d + 1) % NDESC;
        check(desc_ptr == BASE + 32 * idx, "R9 pointer", desc_ptr, BASE + 32 * idx);
    endtask

    initial begin
        int d0, w0, r0, i0;
        void'($urandom(32'd1234));
        for (int w = 0; w < 128; w++) mem[w] = 0;
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check(!rx_ready && !mem_req && !irq, "R1 idle outputs", {rx_ready, mem_req, irq}, 0);
        check(drops == 0 && desc_ptr == BASE, "R1 counter/pointer", desc_ptr, BASE);

        run_frame(16, 16);   // exact fit
        run_frame(16, 17);   // one byte over
        run_frame(1, 5);     // single-byte buffer
        run_frame(60, 56);   // cap below buffer size (R4)
        run_frame(12, 3);

        // R10: software-owned descriptor is skipped
        arm(idx, 20, 1);
        for (int k = 0; k < 64; k++) fb[k] = 8'($urandom);
        d0 = drops; w0 = writes; i0 = irqs;
        send(10);
        repeat (6) @(negedge clk);
        check(drops == 16'(d0 + 1), "R10 drop count", drops, d0 + 1);
        check(writes == w0 && irqs == i0, "R10 no writes or irq", writes - w0, 0);
        check(desc_ptr == BASE + 32 * idx, "R10 pointer held", desc_ptr, BASE + 32 * idx);

        // R11: suspend holds off frame start
        suspend = 1; r0 = reqs;
        rx_valid = 1; rx_sof = 1; rx_eof = 0; rx_data = 8'h11;
        repeat (10) @(negedge clk);
        check(!rx_ready && reqs == r0, "R11 suspended", reqs - r0, 0);
        rx_valid = 0; rx_sof = 0; suspend = 0;
        @(negedge clk);
        run_frame(8, 9);

        for (int n = 0; n < 40; n++) run_frame(1 + $urandom % 48, 1 + $urandom % 56);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule